// File: doc/BRIEF.md
# Macrocell Output and Feedback Control

This block is the last stage of one programmable-logic cell. The cell's logic produces two candidate results: a combinational value and a value that has passed through the cell's flip-flop. This stage picks which of the two reaches the pad. It separately picks which one goes back into the global routing on the buried feedback path, and it decides when the pad's three-state driver is on.

A single configuration word sets everything. Two bits choose the pad result and the feedback result independently. A two-bit direction field makes the pad input-only, output-only or bidirectional. An open-collector bit restricts the driver so that it can only pull the line low, which lets several cells share one wired line such as an interrupt request. In bidirectional mode the driver enable comes from a source selected by a kind field and an index. The source can be either of two global enable pins, in true or inverted form, one line from a group of pad inputs, or one line from a group of other cells' outputs. The value seen at the pad input is always passed on to the routing, so an input-only pad still leaves the cell's feedback logic fully usable.

The block is purely combinational and holds no state. Its only mode is the one encoded in the configuration word, so it has no state register or transitions.

Top module: `mc_output_stage`

## Requirements
- R1: Configuration bit 0 selects the pad data: 1 gives the registered value and 0 gives the combinational value. This applies whenever open-collector mode (bit 4) is off.
- R2: Configuration bit 1 selects the feedback output: 1 gives the registered value and 0 gives the combinational value. This holds for every value of every other configuration bit.
- R3: The pad input value appears unchanged on the routing output in every direction mode.
- R4: The direction field, bits 3:2, set to 00 (input-only) or 11 (treated as input-only) holds the driver enable at 0, whatever the enable source.
- R5: Direction field 01 (output-only) with open-collector off holds the driver enable at 1, whatever the enable source.
- R6: Direction field 10 (bidirectional) makes the driver enable follow the source selected by kind bits 7:5. Kind 0 is global enable pin 0, kind 1 is its inverse, kind 2 is global enable pin 1 and kind 3 is its inverse. Kinds 6 and 7 give 0.
- R7: With open-collector on (bit 4 = 1), the pad data is 0. The driver enable is 1 only when the direction would enable the driver and the selected output value is 0.
- R8: Kind 4 selects pad-group input number idx, and kind 5 selects peer-group output number idx. Here idx is the configuration field that starts at bit 8, of width clog2 of the larger group size. An idx beyond the chosen group's size gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_word | input | 8+IDX_W | Configuration word (fields as in the requirements) |
| comb_val | input | 1 | Combinational result of the cell |
| reg_val | input | 1 | Registered result of the cell |
| oe_pin | input | 2 | Global enable pins |
| pad_group | input | N_PAD | Pad inputs usable as enable source |
| peer_group | input | N_PEER | Other cells' outputs usable as enable source |
| pad_in | input | 1 | Value sensed at the pad |
| pad_oe | output | 1 | Three-state driver enable |
| pad_do | output | 1 | Data driven to the pad |
| fb_out | output | 1 | Buried feedback to the routing |
| pad_to_bus | output | 1 | Pad value to the routing |

## Verification
The bench goes after the cases where the two selectors disagree, with registered and combinational values set opposite. A design that tied the feedback choice to the pad choice would then show the wrong feedback. It sweeps every enable kind in every direction mode. A design that let the enable source leak into input-only or output-only mode would toggle the driver there, and one that dropped an inversion would drive when it should be off. Open-collector runs with a high output value catch a driver that pushes a 1 instead of releasing the line. Index sweeps over both groups catch swapped group or index decoding.

// File: rtl/mc_out_pkg.sv
package mc_out_pkg;

    typedef enum logic [1:0] {
        DIR_INPUT  = 2'b00,
        DIR_OUTPUT = 2'b01,
        DIR_BIDIR  = 2'b10,
        DIR_SPARE  = 2'b11
    } dir_mode_e;

    typedef enum logic [2:0] {
        OE_G0      = 3'd0,
        OE_G0_N    = 3'd1,
        OE_G1      = 3'd2,
        OE_G1_N    = 3'd3,
        OE_PADS    = 3'd4,
        OE_PEERS   = 3'd5,
        OE_RSV6    = 3'd6,
        OE_RSV7    = 3'd7
    } oe_kind_e;

    localparam int BIT_OUT_SEL = 0;
    localparam int BIT_FB_SEL  = 1;
    localparam int BIT_DIR_LO  = 2;
    localparam int BIT_OC      = 4;
    localparam int BIT_KIND_LO = 5;
    localparam int BIT_IDX_LO  = 8;

endpackage

// File: rtl/mc_oe_select.sv
module mc_oe_select
    import mc_out_pkg::*;
#(
    parameter int N_PAD  = 8,
    parameter int N_PEER = 8,
    parameter int IDX_W  = 3
) (
    input  oe_kind_e            kind,
    input  logic [IDX_W-1:0]    idx,
    input  logic [1:0]          oe_pin,
    input  logic [N_PAD-1:0]    pad_group,
    input  logic [N_PEER-1:0]   peer_group,
    output logic                oe_req
);
    localparam int SPAN = 1 << IDX_W;

    logic [SPAN-1:0] pad_span;
    logic [SPAN-1:0] peer_span;

    for (genvar g = 0; g < SPAN; g++) begin : g_span
        if (g < N_PAD) begin : g_pad_live
            assign pad_span[g] = pad_group[g];
        end else begin : g_pad_none
            assign pad_span[g] = 1'b0;
        end
        if (g < N_PEER) begin : g_peer_live
            assign peer_span[g] = peer_group[g];
        end else begin : g_peer_none
            assign peer_span[g] = 1'b0;
        end
    end

    always_comb begin
        unique case (kind)
            OE_G0:    oe_req = oe_pin[0];
            OE_G0_N:  oe_req = ~oe_pin[0];
            OE_G1:    oe_req = oe_pin[1];
            OE_G1_N:  oe_req = ~oe_pin[1];
            OE_PADS:  oe_req = pad_span[idx];
            OE_PEERS: oe_req = peer_span[idx];
            OE_RSV6:  oe_req = 1'b0;
            OE_RSV7:  oe_req = 1'b0;
            default:  oe_req = 1'b0;
        endcase
    end

    always_comb begin
        assert_reserved_off_R6: assert (!((kind == OE_RSV6 || kind == OE_RSV7) && oe_req));
        assert_inverse_pin_R6: assert (!(kind == OE_G0_N && oe_req == oe_pin[0]));
    end
endmodule

// File: rtl/mc_data_select.sv
module mc_data_select (
    input  logic out_sel,
    input  logic fb_sel,
    input  logic comb_val,
    input  logic reg_val,
    output logic out_val,
    output logic fb_out
);
    always_comb begin
        out_val = out_sel ? reg_val : comb_val;
        fb_out  = fb_sel  ? reg_val : comb_val;
    end
endmodule

// File: rtl/mc_pad_drive.sv
module mc_pad_drive
    import mc_out_pkg::*;
(
    input  dir_mode_e dir,
    input  logic      open_coll,
    input  logic      oe_req,
    input  logic      out_val,
    output logic      pad_oe,
    output logic      pad_do
);
    logic dir_en;

    always_comb begin
        unique case (dir)
            DIR_INPUT:  dir_en = 1'b0;
            DIR_OUTPUT: dir_en = 1'b1;
            DIR_BIDIR:  dir_en = oe_req;
            DIR_SPARE:  dir_en = 1'b0;
            default:    dir_en = 1'b0;
        endcase
    end

    always_comb begin
        if (open_coll) begin
            pad_do = 1'b0;
            pad_oe = dir_en & ~out_val;
        end else begin
            pad_do = out_val;
            pad_oe = dir_en;
        end
    end

    always_comb begin
        assert_oc_release_R7: assert (!(open_coll && out_val && pad_oe));
    end
endmodule

// File: rtl/mc_output_stage.sv
module mc_output_stage
    import mc_out_pkg::*;
#(
    parameter int N_PAD  = 8,
    parameter int N_PEER = 8,
    parameter int IDX_W  = $clog2((N_PAD > N_PEER) ? N_PAD : N_PEER),
    parameter int CFG_W  = BIT_IDX_LO + IDX_W
) (
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              comb_val,
    input  logic              reg_val,
    input  logic [1:0]        oe_pin,
    input  logic [N_PAD-1:0]  pad_group,
    input  logic [N_PEER-1:0] peer_group,
    input  logic              pad_in,
    output logic              pad_oe,
    output logic              pad_do,
    output logic              fb_out,
    output logic              pad_to_bus
);
    dir_mode_e        dir;
    oe_kind_e         kind;
    logic [IDX_W-1:0] idx;
    logic             open_coll;
    logic             out_val;
    logic             oe_req;

    always_comb begin
        dir       = dir_mode_e'(cfg_word[BIT_DIR_LO +: 2]);
        kind      = oe_kind_e'(cfg_word[BIT_KIND_LO +: 3]);
        idx       = cfg_word[BIT_IDX_LO +: IDX_W];
        open_coll = cfg_word[BIT_OC];
    end

    mc_data_select u_data (
        .out_sel  (cfg_word[BIT_OUT_SEL]),
        .fb_sel   (cfg_word[BIT_FB_SEL]),
        .comb_val (comb_val),
        .reg_val  (reg_val),
        .out_val  (out_val),
        .fb_out   (fb_out)
    );

    mc_oe_select #(
        .N_PAD  (N_PAD),
        .N_PEER (N_PEER),
        .IDX_W  (IDX_W)
    ) u_oe (
        .kind       (kind),
        .idx        (idx),
        .oe_pin     (oe_pin),
        .pad_group  (pad_group),
        .peer_group (peer_group),
        .oe_req     (oe_req)
    );

    mc_pad_drive u_drive (
        .dir       (dir),
        .open_coll (open_coll),
        .oe_req    (oe_req),
        .out_val   (out_val),
        .pad_oe    (pad_oe),
        .pad_do    (pad_do)
    );

    assign pad_to_bus = pad_in;

    always_comb begin
        assert_input_quiet_R4: assert (!((dir == DIR_INPUT || dir == DIR_SPARE) && pad_oe));
        assert_output_drive_R5: assert (!(dir == DIR_OUTPUT && !open_coll && !pad_oe));
        assert_oc_low_R7: assert (!(open_coll && pad_do));
        assert_fb_pick_R2: assert (fb_out == (cfg_word[BIT_FB_SEL] ? reg_val : comb_val));
        assert_pad_pick_R1: assert (open_coll || pad_do == (cfg_word[BIT_OUT_SEL] ? reg_val : comb_val));
    end
endmodule

// File: tb/test_mc_output_stage.sv
module test_mc_output_stage;
    localparam int NP = 8;
    localparam int NQ = 8;
    localparam int IW = 3;
    localparam int CW = 8 + IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [CW-1:0] cfg_word;
    logic          comb_val, reg_val, pad_in;
    logic [1:0]    oe_pin;
    logic [NP-1:0] pad_group;
    logic [NQ-1:0] peer_group;
    logic          pad_oe, pad_do, fb_out, pad_to_bus;

    mc_output_stage #(.N_PAD(NP), .N_PEER(NQ)) i_mc_output_stage (
        .cfg_word   (cfg_word),
        .comb_val   (comb_val),
        .reg_val    (reg_val),
        .oe_pin     (oe_pin),
        .pad_group  (pad_group),
        .peer_group (peer_group),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_do     (pad_do),
        .fb_out     (fb_out),
        .pad_to_bus (pad_to_bus)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int wd = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", wd);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cfg=%h actual=%b expected=%b", tag, cfg_word, act, exp);
        end
    endtask

    // Behavioural reference, evaluated from the requirements
    task automatic compare_all();
        int d, k, ix;
        bit oc, src, want, v;
        string tg;
        d  = int'(cfg_word[3:2]);
        k  = int'(cfg_word[7:5]);
        ix = int'(cfg_word[10:8]);
        oc = cfg_word[4];
        src = 0;
        if (k == 0) src = oe_pin[0];
        else if (k == 1) src = !oe_pin[0];
        else if (k == 2) src = oe_pin[1];
        else if (k == 3) src = !oe_pin[1];
        else if (k == 4) src = (ix < NP) ? pad_group[ix] : 1'b0;
        else if (k == 5) src = (ix < NQ) ? peer_group[ix] : 1'b0;
        want = (d == 1) ? 1'b1 : ((d == 2) ? src : 1'b0);
        v = cfg_word[0] ? reg_val : comb_val;
        check("R2 feedback", fb_out, cfg_word[1] ? reg_val : comb_val);
        check("R3 pad to bus", pad_to_bus, pad_in);
        if (oc) begin
            check("R7 oc data", pad_do, 1'b0);
            check("R7 oc enable", pad_oe, want && !v);
        end else begin
            check("R1 pad data", pad_do, v);
            if (d == 0 || d == 3) tg = "R4 input quiet";
            else if (d == 1) tg = "R5 output on";
            else if (k == 4 || k == 5) tg = "R8 group index";
            else tg = "R6 bidir source";
            check(tg, pad_oe, want);
        end
    endtask

    task automatic step(input logic [CW-1:0] c, input logic cv, input logic rv,
                        input logic [1:0] op, input logic [NP-1:0] pg,
                        input logic [NQ-1:0] qg, input logic pi);
        @(posedge clk);
        cfg_word = c; comb_val = cv; reg_val = rv; oe_pin = op;
        pad_group = pg; peer_group = qg; pad_in = pi;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        cfg_word = '0; comb_val = 0; reg_val = 1; oe_pin = 2'b11;
        pad_group = '1; peer_group = '1; pad_in = 1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset configuration: input-only, pad released (R4)
        check("R4 reset quiet", pad_oe, 1'b0);
        compare_all();

        // R1/R2: opposite selections with opposite values
        step(11'b000_000_0_01_01, 1'b0, 1'b1, 2'b00, '0, '0, 1'b0);
        step(11'b000_000_0_01_10, 1'b0, 1'b1, 2'b00, '0, '0, 1'b1);
        step(11'b000_000_0_01_10, 1'b1, 1'b0, 2'b00, '0, '0, 1'b0);

        // R4/R5/R6 every kind in every direction, both pin polarities
        for (int d = 0; d < 4; d++)
            for (int k = 0; k < 8; k++)
                for (int p = 0; p < 4; p++)
                    step({3'd0, 3'(k), 1'b0, 2'(d), 2'b00}, 1'b1, 1'b0, 2'(p),
                         8'hA5, 8'h3C, 1'(p));

        // R8: walk a single one through each group
        for (int i = 0; i < 8; i++) begin
            step({3'(i), 3'd4, 1'b0, 2'b10, 2'b00}, 1'b0, 1'b0, 2'b00,
                 8'(1 << i), 8'h00, 1'b0);
            step({3'(i), 3'd5, 1'b0, 2'b10, 2'b00}, 1'b0, 1'b0, 2'b00,
                 8'h00, 8'(1 << i), 1'b0);
            step({3'(i), 3'd5, 1'b0, 2'b10, 2'b00}, 1'b0, 1'b0, 2'b00,
                 8'(1 << i), 8'h00, 1'b0);
        end

        // R7: open collector, high and low output values in each direction
        for (int d = 0; d < 4; d++)
            for (int v = 0; v < 4; v++)
                step({3'd0, 3'd0, 1'b1, 2'(d), 2'b01}, 1'(v), 1'(v >> 1), 2'b01,
                     '0, '0, 1'b1);

        // mixed stimulus
        for (int n = 0; n < 3000; n++)
            step(CW'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                 8'($urandom), 8'($urandom), 1'($urandom));

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule